// File: doc/BRIEF.md
# Fractional-Interval Square-Wave Generator

This block makes a square wave whose frequency can be set more finely than one reference-clock tick. A programmable period word gives the length of one half-period as an integer count of ticks plus a binary fraction of a tick. Each half-period, called an interval here, is timed by a down-counter. At the end of every interval the fraction is added into a running remainder register. When that addition overflows, the next interval gets one extra tick. Successive intervals therefore take only the lengths N and N+1, and over many intervals the average interval equals the programmed value.

A controller writes a new period word with a one-cycle strobe. The word is held and applied at the next interval boundary. A strobe that lands in the boundary cycle itself is applied at once. The remainder register is not cleared by a load, so a change of rate causes no phase jump. The wave output toggles at every boundary. The interval-start output marks the first cycle of each interval.

The control state machine has two states. ST_IDLE is entered on reset. It leaves through the launch transition on the first clock after reset is released, which starts the first interval. ST_RUN then counts ticks. Its wrap transition happens when the counter reaches zero: the next interval is chosen and loaded, and ST_RUN is kept. On any other ST_RUN cycle the count simply continues.

Top module: `frac_period_gen`

## Requirements
- R1: While reset is high, wave_out and interval_start are 0. On the first clock edge after reset is released, interval_start is set, so it is high in the second cycle after release. wave_out is still 0 in that cycle.
- R2: The first interval after reset lasts exactly the clamped integer count N, with no fraction added. Every later interval lasts N ticks, or N+1 when that boundary's addition carries.
- R3: Every interval is N or N+1 ticks long. Over the first eight intervals after reset, the total tick count equals 8·N plus the integer part of 7·F/65536.
- R4: The period word holds the integer count in bits [31:16] and the fraction F in bits [15:0]. At each boundary F is added to a 16-bit remainder. A carry out of bit 15 lengthens the new interval by one tick, and the low 16 bits are kept.
- R5: Let P be N + F/65536. Measured from the first boundary, the m-th later boundary falls at or before m·P ticks, and less than one tick before it.
- R6: wave_out changes only in cycles where interval_start is high, and it inverts in each such cycle except the launch. interval_start never stays high for two cycles in a row.
- R7: A word strobed in mid-interval does not change the interval in progress. It sets the length and the fraction used at the following boundary.
- R8: A word strobed in the cycle in which an interval ends is used for that boundary: both its integer count and its fraction apply to the interval that starts there.
- R9: Loading a word does not clear the remainder.
- R10: An integer field of 0 or 1 is treated as 2, so no interval is shorter than two ticks.
- R11: Reset clears the held word to 0. Until a word is loaded, every interval is 2 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| period_valid | input | 1 | One-cycle strobe that loads period_word |
| period_word | input | 32 | Half-period: integer ticks [31:16], fraction [15:0] |
| wave_out | output | 1 | Square-wave output |
| interval_start | output | 1 | High in the first cycle of each interval |

## Verification
The delicate case is a period-word strobe that falls in the same cycle as an interval boundary. In that cycle the counter reloads and the remainder takes its addition. The bench provokes it by watching interval_start and then counting the exact number of cycles so that the strobe lands on the last tick of a running interval. The new word's fraction is chosen so that the carry differs from what the old fraction would give. It is then judged from the measured lengths of the next two intervals: one would expose a design that applies the word a boundary late, and the other would expose one that mixes the old fraction with the new integer.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fpg_state_e;
endpackage

// File: rtl/fpg_step.sv
// Chooses the next interval length and updates the fractional remainder.
module fpg_step #(
    parameter int INT_W     = 16,
    parameter int FRAC_W    = 16,
    parameter int MIN_TICKS = 2
) (
    input  logic [FRAC_W-1:0] acc_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic              add_i,
    output logic [FRAC_W-1:0] acc_o,
    output logic [INT_W:0]    len_o
);
    localparam logic [INT_W-1:0] MIN_VAL = INT_W'(MIN_TICKS);

    logic [FRAC_W:0]  sum;
    logic             carry;
    logic [INT_W-1:0] base;

    always_comb begin
        sum   = {1'b0, acc_i} + {1'b0, frac_i};
        carry = add_i & sum[FRAC_W];
        acc_o = add_i ? sum[FRAC_W-1:0] : acc_i;
        base  = (int_i < MIN_VAL) ? MIN_VAL : int_i;
        len_o = {1'b0, base} + {{INT_W{1'b0}}, carry};
    end
endmodule

// File: rtl/fpg_down_counter.sv
// Reloadable tick counter; flags the last tick of an interval.
module fpg_down_counter #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/frac_period_gen.sv
module frac_period_gen #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      period_valid,
    input  logic [INT_W+FRAC_W-1:0]   period_word,
    output logic                      wave_out,
    output logic                      interval_start
);
    import fpg_pkg::*;

    localparam int WORD_W = INT_W + FRAC_W;
    localparam int LEN_W  = INT_W + 1;

    fpg_state_e        state_q, state_d;
    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] eff_word;
    logic [FRAC_W-1:0] acc_q, acc_next;
    logic [LEN_W-1:0]  next_len;
    logic              cnt_zero;
    logic              launch, wrap, load;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state and transition decode
    always_comb begin
        launch  = 1'b0;
        wrap    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                launch  = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                wrap    = cnt_zero;
                state_d = ST_RUN;
            end
        endcase
    end

    // A strobe in the boundary cycle bypasses the holding register
    assign eff_word = period_valid ? period_word : held_q;
    assign load     = launch | wrap;

    fpg_step #(
        .INT_W     (INT_W),
        .FRAC_W    (FRAC_W),
        .MIN_TICKS (2)
    ) u_step (
        .acc_i  (acc_q),
        .frac_i (eff_word[FRAC_W-1:0]),
        .int_i  (eff_word[WORD_W-1:FRAC_W]),
        .add_i  (wrap),
        .acc_o  (acc_next),
        .len_o  (next_len)
    );

    fpg_down_counter #(
        .W (LEN_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .val_i  (next_len - LEN_W'(1)),
        .zero_o (cnt_zero)
    );

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q         <= '0;
            acc_q          <= '0;
            wave_out       <= 1'b0;
            interval_start <= 1'b0;
        end else begin
            if (period_valid) held_q <= period_word;
            acc_q          <= acc_next;
            interval_start <= load;
            if (wrap) wave_out <= ~wave_out;
        end
    end
endmodule

// File: rtl/frac_period_gen_chk.sv
module frac_period_gen_chk #(
    parameter int INT_W = 16
) (
    input logic clk,
    input logic rst,
    input logic wave_out,
    input logic interval_start
);
    localparam int GW = INT_W + 2;
    localparam logic [GW-1:0] MAX_GAP = GW'(1 << INT_W);
    localparam logic [GW-1:0] MIN_GAP = GW'(2);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (interval_start) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + GW'(1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!wave_out && !interval_start)); // R1

    AST_LAUNCH_NEXT: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !rst) |=> interval_start); // R1

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        interval_start |=> !interval_start); // R6

    AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !interval_start |-> $stable(wave_out)); // R6

    AST_INTERVAL_SPAN: assert property (@(posedge clk) disable iff (rst)
        (interval_start && seen_q) |-> (gap_q >= MIN_GAP && gap_q <= MAX_GAP)); // R10
endmodule

bind frac_period_gen frac_period_gen_chk #(.INT_W(INT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wave_out       (wave_out),
    .interval_start (interval_start)
);

// File: tb/frac_period_gen_test.sv
module frac_period_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {integer field, fraction field, expected total ticks over 8 intervals}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd5,  16'h8000, 16'd43},
        {16'd3,  16'h4000, 16'd25},
        {16'd10, 16'h0000, 16'd80},
        {16'd2,  16'hFFFF, 16'd22},
        {16'd0,  16'h8000, 16'd19},
        {16'd1,  16'h0000, 16'd16},
        {16'd7,  16'h5555, 16'd58}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        period_valid = 1'b0;
    logic [31:0] period_word = '0;
    logic        wave_out, interval_start;

    int n_checks = 0;
    int n_fail   = 0;
    int ncyc     = 0;
    int nst      = 0;
    int base     = 0;
    int wave_err = 0;
    int stamps [0:511];
    logic prev_wave = 1'b0;
    bit   first_pending = 1'b1;

    frac_period_gen uut (
        .clk            (clk),
        .rst            (rst),
        .period_valid   (period_valid),
        .period_word    (period_word),
        .wave_out       (wave_out),
        .interval_start (interval_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: time-stamp interval starts, watch the wave (R6)
    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (rst) begin
            first_pending = 1'b1;
            prev_wave     = 1'b0;
        end else begin
            if (interval_start) begin
                if (nst < 512) stamps[nst] = ncyc;
                nst = nst + 1;
                if (first_pending) begin
                    if (wave_out !== 1'b0) wave_err = wave_err + 1;
                    first_pending = 1'b0;
                end else if (wave_out === prev_wave) begin
                    wave_err = wave_err + 1;
                end
            end else if (wave_out !== prev_wave) begin
                wave_err = wave_err + 1;
            end
            prev_wave = wave_out;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] w, input bit load);
        @(negedge clk);
        rst = 1'b1;
        period_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(wave_out == 1'b0 && interval_start == 1'b0, "R1 reset outputs",
              {wave_out, interval_start}, 0);
        @(negedge clk);
        rst          = 1'b0;
        period_valid = load;
        period_word  = w;
        base         = nst;
        @(negedge clk);
        #1;
        period_valid = 1'b0;
        check(interval_start == 1'b1 && wave_out == 1'b0, "R1 launch cycle",
              {wave_out, interval_start}, 1);
    endtask

    task automatic wait_starts(input int count);
        while (nst < base + count) begin
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int ilen(input int k);
        return stamps[base + k + 1] - stamps[base + k];
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        // Vector table: length sequence, long-term total, edge error
        for (int i = 0; i < NVEC; i++) begin
            int  nint, frac, nc, exp_total;
            bit  in_range;
            bit  grid_ok;
            longint p;
            nint      = int'(VEC[i][47:32]);
            frac      = int'(VEC[i][31:16]);
            exp_total = int'(VEC[i][15:0]);
            nc        = (nint < 2) ? 2 : nint; // R10
            do_reset({VEC[i][47:32], VEC[i][31:16]}, 1'b1);
            wait_starts(9);
            check(ilen(0) == nc, "R2 first interval", ilen(0), nc);
            in_range = 1'b1;
            for (int k = 0; k < 8; k++)
                if (ilen(k) != nc && ilen(k) != nc + 1) in_range = 1'b0;
            check(in_range, "R3 two lengths only", ilen(7), nc);
            check(stamps[base+8] - stamps[base] == exp_total, "R3 R4 R10 eight-interval total",
                  stamps[base+8] - stamps[base], exp_total);
            p = 65536 * longint'(nc) + longint'(frac);
            grid_ok = 1'b1;
            for (int m = 1; m <= 7; m++) begin
                longint e;
                e = longint'(stamps[base+1+m] - stamps[base+1]);
                if (!(65536 * e <= m * p && m * p < 65536 * (e + 1))) grid_ok = 1'b0;
            end
            check(grid_ok, "R5 edge within one tick", stamps[base+8] - stamps[base+1], 7 * p / 65536);
        end

        // R11: no word loaded, intervals of 2 ticks
        do_reset(32'h0009_0000, 1'b0);
        wait_starts(4);
        check(ilen(0) == 2 && ilen(1) == 2 && ilen(2) == 2, "R11 default interval",
              ilen(1), 2);

        // R7 and R9: mid-interval load, remainder carried across the load
        do_reset({16'd20, 16'h8000}, 1'b1);
        wait_starts(2);
        repeat (5) @(negedge clk);
        period_valid = 1'b1;
        period_word  = {16'd4, 16'h8000};
        @(negedge clk);
        period_valid = 1'b0;
        wait_starts(5);
        check(ilen(1) == 20, "R7 current interval unchanged", ilen(1), 20);
        check(ilen(2) == 5, "R9 remainder kept through load", ilen(2), 5);
        check(ilen(3) == 4, "R7 new word in force", ilen(3), 4);

        // R8: load lands in the boundary cycle
        do_reset({16'd6, 16'h8000}, 1'b1);
        wait_starts(2);
        repeat (5) @(negedge clk);
        period_valid = 1'b1;
        period_word  = {16'd3, 16'h4000};
        @(negedge clk);
        period_valid = 1'b0;
        wait_starts(5);
        check(ilen(1) == 6, "R8 interval before boundary load", ilen(1), 6);
        check(ilen(2) == 3, "R8 boundary load uses new fraction", ilen(2), 3);
        check(ilen(3) == 4, "R8 R4 carry after boundary load", ilen(3), 4);

        check(wave_err == 0, "R6 wave toggles only at interval starts", wave_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule